// File: doc/BRIEF.md
# Serial Controller Status Word

This block holds the eight-bit status word of a programmable serial communications controller. The receiver and transmitter report single-cycle events to it: a character was assembled, the CPU read the receive holding register, the CPU loaded the transmit holding register, the transmitter moved that character into its shift register, and parity, overrun, framing, SYN and DLE conditions. It also watches two active-low modem inputs, the data-set-ready line and the carrier-detect line, through synchronizers. The word is presented for CPU reads on a parallel bus. Three active-low pins report transmit ready, receive ready and the combined shift-empty / data-set-change condition.

Several bits change meaning with the character framing mode. The error bits are cleared by a one-cycle reset command that is not stored. The submode setting (normal, echo or SYN/DLE strip, local loopback, remote loopback) forces some pins and masks some bits.

Top module: `sio_status_reg`

## Requirements
- R1: After reset `status` is 8'h00 and `txrdy_n`, `rxrdy_n` and `txemt_n` are all 1. The bit order from bit 7 down to bit 0 is: DSR active, DCD active, framing/SYN, overrun, parity/DLE, shift-empty/data-set-change, RxRDY, TxRDY.
- R2: Bit 7 reads 1 while `dsr_n` is low and bit 6 reads 1 while `dcd_n` is low. Each line passes through a two-stage synchronizer, so a change is visible after the second rising clock edge and not after the first.
- R3: With `sync_mode`=0, bit 5 is set by `frm_err` and `syn_det` has no effect. With `sync_mode`=1, bit 5 is set by `syn_det`.
- R4: With `sync_mode`=0, bit 3 is set by `par_err` only and `dle_det` is ignored. With `sync_mode`=1, bit 3 is set by `par_err` or `dle_det`.
- R5: Bit 4 sets when `rx_char` arrives while bit 1 is already 1 and `rhr_rd` is not asserted in that cycle. It then stays set until an error reset.
- R6: `err_reset` clears bits 5, 4 and 3 on the edge where it is sampled, and only then. If a set event for one of those bits arrives in the same cycle, that bit is set. Bits 7, 6, 2, 1 and 0 are not affected.
- R7: Bit 2 is 1 when the data-set-change latch is set or when `tsr_empty` was 1 at the previous edge. The latch sets on any change of either synchronized modem line and clears on `stat_rd`. In echo submode (`submode`=2'b01 with `sync_mode`=0), bit 2 shows the latch only.
- R8: Bit 1 sets on `rx_char` and clears on `rhr_rd`, and a set wins over a clear in the same cycle. In remote loopback (`submode`=2'b11), `rx_char` does not set it.
- R9: Bit 0 equals `tx_en` AND "holding register empty". A `thr_load` fills the holding register and a `thr_xfer` empties it, with load winning if both occur together. Enabling the transmitter while a character waits leaves bit 0 at 0.
- R10: The pins are the active-low inverse of bits 0, 1 and 2. In echo and remote loopback submodes, bit 0 is 0 and `txrdy_n` is 1. In remote loopback, `rxrdy_n` and `txemt_n` are also held at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sync_mode | input | 1 | 1 = synchronous character framing, 0 = asynchronous |
| submode | input | 2 | 00 normal, 01 echo (async) / strip (sync), 10 local loopback, 11 remote loopback |
| tx_en | input | 1 | Transmitter enable |
| err_reset | input | 1 | One-cycle command that clears the error bits |
| stat_rd | input | 1 | CPU read of the status word; clears the data-set-change latch |
| rx_char | input | 1 | Receiver assembled a character |
| rhr_rd | input | 1 | CPU read of the receive holding register |
| thr_load | input | 1 | CPU loaded the transmit holding register |
| thr_xfer | input | 1 | Holding register moved to the transmit shift register |
| tsr_empty | input | 1 | Transmit shift register empty (level) |
| par_err | input | 1 | Parity error event |
| frm_err | input | 1 | Framing error event |
| syn_det | input | 1 | SYN character detected event |
| dle_det | input | 1 | DLE character received event |
| dsr_n | input | 1 | Data-set-ready modem line, active low, asynchronous |
| dcd_n | input | 1 | Carrier-detect modem line, active low, asynchronous |
| status | output | 8 | Status word |
| txrdy_n | output | 1 | Transmit ready pin, active low |
| rxrdy_n | output | 1 | Receive ready pin, active low |
| txemt_n | output | 1 | Shift-empty / data-set-change pin, active low |

## Verification
A wrong sticky flag shows on the status word at the first sample after the edge that should have set or cleared it. It then persists there until the next error reset or read, so any later vector that expects a clean word also reports it. A wrong holding-register or RxRDY flag appears on both the status bit and its pin one cycle after the load, transfer, character or read event. A fault in the synchronizer depth shows as a modem bit or change latch that appears one cycle early or late around the second edge after the line moves. Submode forcing errors show at once on the pins, in the same cycle the submode is applied.

// File: rtl/sio_stat_pkg.sv
package sio_stat_pkg;

    typedef enum logic [1:0] {
        SUB_NORMAL = 2'b00,
        SUB_ECHO   = 2'b01,
        SUB_LOCAL  = 2'b10,
        SUB_REMOTE = 2'b11
    } submode_e;

    localparam int STAT_W     = 8;
    localparam int BIT_DSR    = 7;
    localparam int BIT_DCD    = 6;
    localparam int BIT_FE_SYN = 5;
    localparam int BIT_OVR    = 4;
    localparam int BIT_PE_DLE = 3;
    localparam int BIT_EMT    = 2;
    localparam int BIT_RXRDY  = 1;
    localparam int BIT_TXRDY  = 0;

endpackage

// File: rtl/sio_modem_mon.sv
module sio_modem_mon #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic dsr_n_i,
    input  logic dcd_n_i,
    input  logic stat_rd_i,
    output logic dsr_act_o,
    output logic dcd_act_o,
    output logic dsc_o
);
    localparam int LAST = SYNC_STAGES - 1;

    typedef struct packed {
        logic [SYNC_STAGES-1:0] dsr_sh;
        logic [SYNC_STAGES-1:0] dcd_sh;
        logic                   dsc;
    } mon_state_t;

    mon_state_t st_d, st_q;
    logic       line_moves;

    always_comb begin
        st_d = st_q;
        st_d.dsr_sh = {st_q.dsr_sh[SYNC_STAGES-2:0], dsr_n_i};
        st_d.dcd_sh = {st_q.dcd_sh[SYNC_STAGES-2:0], dcd_n_i};
        // the final stage will take a new value at this edge
        line_moves = (st_q.dsr_sh[LAST-1] != st_q.dsr_sh[LAST]) ||
                     (st_q.dcd_sh[LAST-1] != st_q.dcd_sh[LAST]);
        if (stat_rd_i) begin
            st_d.dsc = 1'b0;
        end
        if (line_moves) begin
            st_d.dsc = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.dsr_sh <= '1;
            st_q.dcd_sh <= '1;
            st_q.dsc    <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign dsr_act_o = ~st_q.dsr_sh[LAST];
    assign dcd_act_o = ~st_q.dcd_sh[LAST];
    assign dsc_o     = st_q.dsc;

    assert_dsc_capture_R7: assert property (@(posedge clk) disable iff (!rst_n)
        line_moves |=> st_q.dsc);

    assert_dsc_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_rd_i && !line_moves) |=> !st_q.dsc);

    initial begin
        assert_stages_R2: assert (SYNC_STAGES >= 2);
    end

endmodule

// File: rtl/sio_rx_flags.sv
module sio_rx_flags (
    input  logic clk,
    input  logic rst_n,
    input  logic sync_mode_i,
    input  logic remote_i,
    input  logic rx_char_i,
    input  logic rhr_rd_i,
    input  logic par_err_i,
    input  logic frm_err_i,
    input  logic syn_det_i,
    input  logic dle_det_i,
    input  logic err_reset_i,
    output logic rxrdy_o,
    output logic fe_syn_o,
    output logic ovr_o,
    output logic pe_dle_o
);
    typedef struct packed {
        logic rxrdy;
        logic fe_syn;
        logic ovr;
        logic pe_dle;
    } rx_state_t;

    rx_state_t st_d, st_q;
    logic      set_fe_syn;
    logic      set_ovr;
    logic      set_pe_dle;

    always_comb begin
        set_fe_syn = sync_mode_i ? syn_det_i : frm_err_i;
        set_pe_dle = par_err_i | (sync_mode_i & dle_det_i);
        set_ovr    = rx_char_i & st_q.rxrdy & ~rhr_rd_i & ~remote_i;

        st_d = st_q;
        if (err_reset_i) begin
            st_d.fe_syn = 1'b0;
            st_d.ovr    = 1'b0;
            st_d.pe_dle = 1'b0;
        end
        if (set_fe_syn) st_d.fe_syn = 1'b1;
        if (set_ovr)    st_d.ovr    = 1'b1;
        if (set_pe_dle) st_d.pe_dle = 1'b1;

        if (rhr_rd_i) st_d.rxrdy = 1'b0;
        if (rx_char_i && !remote_i) st_d.rxrdy = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rxrdy_o  = st_q.rxrdy;
    assign fe_syn_o = st_q.fe_syn;
    assign ovr_o    = st_q.ovr;
    assign pe_dle_o = st_q.pe_dle;

    assert_errclr_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (err_reset_i && !frm_err_i && !syn_det_i && !par_err_i && !dle_det_i && !rx_char_i)
        |=> (!fe_syn_o && !ovr_o && !pe_dle_o));

    assert_ovr_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (ovr_o && !err_reset_i) |=> ovr_o);

    assert_rxrdy_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_char_i && !remote_i) |=> rxrdy_o);

    assert_async_dle_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!sync_mode_i && !pe_dle_o && !par_err_i) |=> !pe_dle_o);

endmodule

// File: rtl/sio_tx_flags.sv
module sio_tx_flags (
    input  logic clk,
    input  logic rst_n,
    input  logic tx_en_i,
    input  logic force_tx_i,
    input  logic echo_i,
    input  logic thr_load_i,
    input  logic thr_xfer_i,
    input  logic tsr_empty_i,
    input  logic dsc_i,
    output logic txrdy_o,
    output logic emt_o
);
    typedef struct packed {
        logic thr_full;
        logic tsr_empty;
    } tx_state_t;

    tx_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        st_d.tsr_empty = tsr_empty_i;
        if (thr_xfer_i) st_d.thr_full = 1'b0;
        if (thr_load_i) st_d.thr_full = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign txrdy_o = tx_en_i & ~st_q.thr_full & ~force_tx_i;
    assign emt_o   = dsc_i | (st_q.tsr_empty & ~echo_i);

    assert_load_fills_R9: assert property (@(posedge clk) disable iff (!rst_n)
        thr_load_i |=> !txrdy_o || !$past(tx_en_i) || (tx_en_i != $past(tx_en_i)) || st_q.thr_full);

    assert_xfer_frees_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (thr_xfer_i && !thr_load_i) |=> !st_q.thr_full);

endmodule

// File: rtl/sio_status_reg.sv
module sio_status_reg
    import sio_stat_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sync_mode,
    input  logic [1:0]        submode,
    input  logic              tx_en,
    input  logic              err_reset,
    input  logic              stat_rd,
    input  logic              rx_char,
    input  logic              rhr_rd,
    input  logic              thr_load,
    input  logic              thr_xfer,
    input  logic              tsr_empty,
    input  logic              par_err,
    input  logic              frm_err,
    input  logic              syn_det,
    input  logic              dle_det,
    input  logic              dsr_n,
    input  logic              dcd_n,
    output logic [STAT_W-1:0] status,
    output logic              txrdy_n,
    output logic              rxrdy_n,
    output logic              txemt_n
);
    submode_e sub;
    logic     echo;
    logic     remote;
    logic     force_tx;
    logic     dsr_act, dcd_act, dsc;
    logic     rxrdy, fe_syn, ovr, pe_dle;
    logic     txrdy, emt;

    assign sub      = submode_e'(submode);
    assign echo     = !sync_mode && (sub == SUB_ECHO);
    assign remote   = (sub == SUB_REMOTE);
    assign force_tx = echo || remote;

    sio_modem_mon #(.SYNC_STAGES(SYNC_STAGES)) u_modem (
        .clk       (clk),
        .rst_n     (rst_n),
        .dsr_n_i   (dsr_n),
        .dcd_n_i   (dcd_n),
        .stat_rd_i (stat_rd),
        .dsr_act_o (dsr_act),
        .dcd_act_o (dcd_act),
        .dsc_o     (dsc)
    );

    sio_rx_flags u_rx (
        .clk         (clk),
        .rst_n       (rst_n),
        .sync_mode_i (sync_mode),
        .remote_i    (remote),
        .rx_char_i   (rx_char),
        .rhr_rd_i    (rhr_rd),
        .par_err_i   (par_err),
        .frm_err_i   (frm_err),
        .syn_det_i   (syn_det),
        .dle_det_i   (dle_det),
        .err_reset_i (err_reset),
        .rxrdy_o     (rxrdy),
        .fe_syn_o    (fe_syn),
        .ovr_o       (ovr),
        .pe_dle_o    (pe_dle)
    );

    sio_tx_flags u_tx (
        .clk         (clk),
        .rst_n       (rst_n),
        .tx_en_i     (tx_en),
        .force_tx_i  (force_tx),
        .echo_i      (echo),
        .thr_load_i  (thr_load),
        .thr_xfer_i  (thr_xfer),
        .tsr_empty_i (tsr_empty),
        .dsc_i       (dsc),
        .txrdy_o     (txrdy),
        .emt_o       (emt)
    );

    always_comb begin
        status             = '0;
        status[BIT_DSR]    = dsr_act;
        status[BIT_DCD]    = dcd_act;
        status[BIT_FE_SYN] = fe_syn;
        status[BIT_OVR]    = ovr;
        status[BIT_PE_DLE] = pe_dle;
        status[BIT_EMT]    = emt;
        status[BIT_RXRDY]  = rxrdy;
        status[BIT_TXRDY]  = txrdy;
    end

    assign txrdy_n = ~txrdy;
    assign rxrdy_n = remote ? 1'b1 : ~rxrdy;
    assign txemt_n = remote ? 1'b1 : ~emt;

    assert_forced_txrdy_R10: assert property (@(posedge clk) disable iff (!rst_n)
        force_tx |-> (txrdy_n && !status[BIT_TXRDY]));

    assert_remote_pins_R10: assert property (@(posedge clk) disable iff (!rst_n)
        remote |-> (rxrdy_n && txemt_n));

    assert_emt_echo_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (echo && !dsc) |-> !status[BIT_EMT]);

endmodule

// File: tb/sio_status_reg_tb_top.sv
module sio_status_reg_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sync_mode = 1'b0;
    logic [1:0] submode = 2'b00;
    logic       tx_en = 1'b0;
    logic       err_reset = 1'b0, stat_rd = 1'b0, rx_char = 1'b0, rhr_rd = 1'b0;
    logic       thr_load = 1'b0, thr_xfer = 1'b0, tsr_empty = 1'b0;
    logic       par_err = 1'b0, frm_err = 1'b0, syn_det = 1'b0, dle_det = 1'b0;
    logic       dsr_n = 1'b1, dcd_n = 1'b1;
    logic [7:0] status;
    logic       txrdy_n, rxrdy_n, txemt_n;

    int errors = 0;
    int checks = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    sio_status_reg dut_i (
        .clk(clk), .rst_n(rst_n), .sync_mode(sync_mode), .submode(submode),
        .tx_en(tx_en), .err_reset(err_reset), .stat_rd(stat_rd), .rx_char(rx_char),
        .rhr_rd(rhr_rd), .thr_load(thr_load), .thr_xfer(thr_xfer), .tsr_empty(tsr_empty),
        .par_err(par_err), .frm_err(frm_err), .syn_det(syn_det), .dle_det(dle_det),
        .dsr_n(dsr_n), .dcd_n(dcd_n), .status(status), .txrdy_n(txrdy_n),
        .rxrdy_n(rxrdy_n), .txemt_n(txemt_n)
    );

    // event field: {err_reset, stat_rd, rx_char, rhr_rd, thr_load, thr_xfer, tsr_empty, par, frm, syn, dle}
    localparam logic [10:0] E_NONE = 11'h000;
    localparam logic [10:0] E_ERR  = 11'h400;
    localparam logic [10:0] E_RX   = 11'h100;
    localparam logic [10:0] E_RHR  = 11'h080;
    localparam logic [10:0] E_LD   = 11'h040;
    localparam logic [10:0] E_XF   = 11'h020;
    localparam logic [10:0] E_TSR  = 11'h010;
    localparam logic [10:0] E_PAR  = 11'h008;
    localparam logic [10:0] E_FRM  = 11'h004;
    localparam logic [10:0] E_SYN  = 11'h002;
    localparam logic [10:0] E_DLE  = 11'h001;

    // pins field: {txrdy_n, rxrdy_n, txemt_n}
    function automatic logic [31:0] mk(input logic sy, input logic [1:0] sb, input logic te,
                                       input logic [10:0] ev, input logic [7:0] st,
                                       input logic [2:0] pins);
        return {sy, sb, te, ev, st, pins, 6'b0};
    endfunction

    localparam int NV = 27;
    localparam logic [31:0] VEC [NV] = '{
        mk(0, 2'd0, 1, E_NONE,        8'h01, 3'b011), // 0  R9 enable sets TxRDY
        mk(0, 2'd0, 1, E_LD,          8'h00, 3'b111), // 1  R9 load
        mk(0, 2'd0, 1, E_XF,          8'h01, 3'b011), // 2  R9 transfer
        mk(0, 2'd0, 0, E_LD,          8'h00, 3'b111), // 3  R9 load while disabled
        mk(0, 2'd0, 1, E_NONE,        8'h00, 3'b111), // 4  R9 enable with char waiting
        mk(0, 2'd0, 1, E_XF,          8'h01, 3'b011), // 5  R9
        mk(0, 2'd0, 1, E_RX,          8'h03, 3'b001), // 6  R8
        mk(0, 2'd0, 1, E_RX,          8'h13, 3'b001), // 7  R5 overrun
        mk(0, 2'd0, 1, E_RHR,         8'h11, 3'b011), // 8  R5 sticky, R8 clear
        mk(0, 2'd0, 1, E_PAR | E_FRM, 8'h39, 3'b011), // 9  R3 R4 async
        mk(0, 2'd0, 1, E_SYN | E_DLE, 8'h39, 3'b011), // 10 R4 async ignores SYN/DLE
        mk(0, 2'd0, 1, E_ERR,         8'h01, 3'b011), // 11 R6
        mk(0, 2'd0, 1, E_TSR,         8'h05, 3'b010), // 12 R7 shift empty
        mk(1, 2'd0, 1, E_SYN,         8'h21, 3'b011), // 13 R3 sync
        mk(1, 2'd0, 1, E_DLE,         8'h29, 3'b011), // 14 R4 sync
        mk(1, 2'd0, 1, E_ERR | E_PAR, 8'h09, 3'b011), // 15 R6 set wins
        mk(1, 2'd0, 1, E_ERR,         8'h01, 3'b011), // 16 R6
        mk(1, 2'd1, 1, E_NONE,        8'h01, 3'b011), // 17 R10 strip is not echo
        mk(0, 2'd1, 1, E_NONE,        8'h00, 3'b111), // 18 R10 echo
        mk(0, 2'd1, 1, E_TSR,         8'h00, 3'b111), // 19 R7 echo masks shift empty
        mk(0, 2'd3, 1, E_RX | E_FRM,  8'h20, 3'b111), // 20 R8 remote
        mk(0, 2'd3, 1, E_TSR,         8'h24, 3'b111), // 21 R10 remote pins
        mk(0, 2'd0, 1, E_ERR,         8'h01, 3'b011), // 22 R6
        mk(0, 2'd2, 1, E_NONE,        8'h01, 3'b011), // 23 R10 local loop
        mk(0, 2'd0, 1, E_RX,          8'h03, 3'b001), // 24 R8
        mk(0, 2'd0, 1, E_RX | E_RHR,  8'h03, 3'b001), // 25 R5 R8 no overrun on read
        mk(0, 2'd0, 1, E_RHR,         8'h01, 3'b011)  // 26 R8
    };

    function automatic string tag_of(input int i);
        case (i)
            0, 1, 2, 3, 4, 5: return "R9";
            6, 20, 24, 26:    return "R8";
            7, 8, 25:         return "R5";
            9, 13:            return "R3";
            10, 14:           return "R4";
            11, 15, 16, 22:   return "R6";
            12, 19:           return "R7";
            default:          return "R10";
        endcase
    endfunction

    task automatic check(input string req, input logic [7:0] exp_st, input logic [2:0] exp_pins);
        checks++;
        if (status !== exp_st || {txrdy_n, rxrdy_n, txemt_n} !== exp_pins) begin
            errors++;
            $display("FAIL %s: status=%h pins=%b expected status=%h pins=%b",
                     req, status, {txrdy_n, rxrdy_n, txemt_n}, exp_st, exp_pins);
        end
    endtask

    task automatic clear_events();
        {err_reset, stat_rd, rx_char, rhr_rd, thr_load, thr_xfer, tsr_empty,
         par_err, frm_err, syn_det, dle_det} = E_NONE;
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    initial begin : watchdog
        repeat (5000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: run did not complete");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin : main
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1", 8'h00, 3'b111);
        rst_n = 1'b1;
        step();
        check("R1", 8'h00, 3'b111);

        for (int i = 0; i < NV; i++) begin
            logic [31:0] v;
            v = VEC[i];
            sync_mode = v[31];
            submode   = v[30:29];
            tx_en     = v[28];
            {err_reset, stat_rd, rx_char, rhr_rd, thr_load, thr_xfer, tsr_empty,
             par_err, frm_err, syn_det, dle_det} = v[27:17];
            step();
            check(tag_of(i), v[16:9], v[8:6]);
        end
        clear_events();
        sync_mode = 1'b0;
        submode   = 2'b00;
        tx_en     = 1'b1;
        step();
        check("R9", 8'h01, 3'b011);

        // R2 modem line through two-stage synchronizer, R7 change latch
        dsr_n = 1'b0;
        step();
        check("R2", 8'h01, 3'b011);
        step();
        check("R2", 8'h85, 3'b010);
        stat_rd = 1'b1;
        step();
        stat_rd = 1'b0;
        check("R7", 8'h81, 3'b011);
        dcd_n = 1'b0;
        step();
        step();
        check("R2", 8'hC5, 3'b010);
        err_reset = 1'b1;
        step();
        err_reset = 1'b0;
        check("R6", 8'hC5, 3'b010);
        dsr_n = 1'b1;
        dcd_n = 1'b1;
        step();
        step();
        check("R7", 8'h05, 3'b010);
        stat_rd = 1'b1;
        step();
        stat_rd = 1'b0;
        check("R7", 8'h01, 3'b011);

        // R9 load and transfer in the same cycle: load wins
        thr_load = 1'b1;
        thr_xfer = 1'b1;
        step();
        clear_events();
        check("R9", 8'h00, 3'b111);

        // R1 reset in the middle of activity
        rx_char = 1'b1;
        frm_err = 1'b1;
        step();
        clear_events();
        rst_n = 1'b0;
        tx_en = 1'b0;
        @(negedge clk);
        check("R1", 8'h00, 3'b111);
        rst_n = 1'b1;
        step();

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule